// File: doc/BRIEF.md
# Memory-Only Instruction Execute Unit

This block carries out the operation step of a small instruction set that has no programmer-visible registers: every instruction reads and writes whole memory words. A word holds a 4-bit opcode, two 2-bit mode fields, an A-field and a B-field; fields are unsigned values from 0 to `CORE`-1, and all field arithmetic wraps modulo `CORE`. Fetch and operand resolution happen upstream. The block receives the current program counter, the instruction word, and both operands already resolved: each comes as an address, the word stored there and an immediate flag.

For each accepted instruction the block produces, one clock cycle later, at most one memory write (address and full word) and one command for the process scheduler. The command says whether the process continues at PC+1, branches, skips to PC+2, spawns a second process, or dies. An immediate A operand narrows the data operations to the B-field only. A non-immediate A operand makes them act on the whole word or on both fields. Comparisons never branch; they only skip.

Top module: `mo_exec_unit`

## Requirements
- R1: After reset, and in any cycle that follows a cycle with `in_valid` low, `out_valid`, `wr_en`, `cmd`, `next_pc`, `spawn_pc`, `wr_addr` and `wr_data` are all zero. Results appear exactly one clock after the cycle in which `in_valid` is high. `wr_addr` and `wr_data` are zero whenever `wr_en` is low.
- R2: The word layout is opcode in bits [WW-1:WW-4], A-mode in the next 2 bits, B-mode in the next 2 bits, A-field in [2FW-1:FW] and B-field in [FW-1:0]. The opcodes are 0 halt, 1 move, 2 add, 3 subtract, 4 jump, 5 jump-if-zero, 6 jump-if-nonzero, 7 compare-skip, 8 less-than-skip, 9 decrement-and-jump, 10 split. Codes 0 and 11 to 15 produce `cmd`=5 (halt), with no write and with `next_pc`=`spawn_pc`=0. An all-zero word is therefore a halt with zero fields.
- R3: Move with an immediate A writes the target word with only its B-field replaced by the instruction's A-field. With a non-immediate A it writes the whole A word to the target address. The command is continue.
- R4: Add or subtract with an immediate A writes the target with its B-field combined with the instruction's A-field, modulo `CORE`. Otherwise the A-fields are combined with each other and the B-fields with each other; the opcode and modes are kept from the target.
- R5: Jump always gives `cmd`=2 (branch) with `next_pc` = A address. Jump-if-zero branches when the target B-field is zero and jump-if-nonzero branches when it is nonzero; when the condition fails, the result is continue. None of them writes.
- R6: Compare-skip with an immediate A tests the instruction's A-field against the target B-field. Otherwise it tests the complete A word against the complete target word, opcode and modes included. Equality gives `cmd`=3 (skip) and inequality gives continue. No write.
- R7: Less-than-skip takes the instruction's A-field when A is immediate and otherwise the B-field of the A word. If that value is unsigned-less than the target B-field, the result is skip; otherwise it is continue. No write.
- R8: Decrement-and-jump writes the target with its B-field decremented modulo `CORE` (0 becomes `CORE`-1). It branches to the A address when the new value is nonzero and continues when it is zero.
- R9: Split gives `cmd`=4 (spawn) with `next_pc`=PC+1 (queued first) and `spawn_pc` = A address (queued second), and it does not write.
- R10: Continue (`cmd`=1) sets `next_pc` to PC+1 and skip sets it to PC+2, both modulo `CORE`, so that PC `CORE`-1 continues to 0 and skips to 1.
- R11: When `b_imm` is high, the target word is the instruction itself at address `pc`, and `b_ptr`/`b_word` are ignored. Decrement-and-jump with an immediate B therefore decrements the instruction's own B-field and writes it back to `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction with resolved operands is presented |
| pc | input | FW | Address of the executing instruction |
| instr | input | WW | The instruction word |
| a_imm | input | 1 | A operand is immediate |
| a_ptr | input | FW | Resolved A address |
| a_word | input | WW | Word stored at the A address |
| b_imm | input | 1 | B operand is immediate (target is the instruction itself) |
| b_ptr | input | FW | Resolved B (target) address |
| b_word | input | WW | Word stored at the B address |
| out_valid | output | 1 | Result registers hold a result |
| cmd | output | 3 | Scheduler command: 0 idle, 1 continue, 2 branch, 3 skip, 4 spawn, 5 halt |
| next_pc | output | FW | First address to queue for the process |
| spawn_pc | output | FW | Second address to queue (spawn only) |
| wr_en | output | 1 | Memory write request |
| wr_addr | output | FW | Memory write address |
| wr_data | output | WW | Memory write word |

## Verification
The hardest situations to reach are the modular wrap points. Subtraction must borrow across zero, addition must reach exactly `CORE`, a decrement must take zero to `CORE`-1, and PC+2 must fold past the top of memory. With a power-of-two core, all of these hide behind plain bit truncation. The bench therefore builds the unit with a ten-word core and sweeps every pair of field values for add, subtract and less-than. It rotates the PC through every address, including 8 and 9, so the wrapped continue and skip targets are each observed. Whole-word compare is tested with words that differ in only the opcode, only a mode, or only one field.

// File: rtl/mo_exec_pkg.sv
package mo_exec_pkg;

    localparam logic [3:0] OPC_HALT = 4'd0;
    localparam logic [3:0] OPC_MOVE = 4'd1;
    localparam logic [3:0] OPC_ADD  = 4'd2;
    localparam logic [3:0] OPC_SUB  = 4'd3;
    localparam logic [3:0] OPC_JUMP = 4'd4;
    localparam logic [3:0] OPC_JZ   = 4'd5;
    localparam logic [3:0] OPC_JNZ  = 4'd6;
    localparam logic [3:0] OPC_CEQ  = 4'd7;
    localparam logic [3:0] OPC_CLT  = 4'd8;
    localparam logic [3:0] OPC_DJMP = 4'd9;
    localparam logic [3:0] OPC_FORK = 4'd10;

    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_NEXT   = 3'd1,
        CMD_BRANCH = 3'd2,
        CMD_SKIP   = 3'd3,
        CMD_SPAWN  = 3'd4,
        CMD_HALT   = 3'd5
    } sched_cmd_e;

    typedef struct packed {
        logic halt;
        logic move;
        logic add;
        logic sub;
        logic jump;
        logic jz;
        logic jnz;
        logic ceq;
        logic clt;
        logic djmp;
        logic fork_op;
    } op_class_t;

endpackage

// File: rtl/mo_exec_decode.sv
module mo_exec_decode
    import mo_exec_pkg::*;
(
    input  logic [3:0] opcode,
    output op_class_t  cls
);

    always_comb begin
        cls = '0;
        case (opcode)
            OPC_MOVE: cls.move    = 1'b1;
            OPC_ADD:  cls.add     = 1'b1;
            OPC_SUB:  cls.sub     = 1'b1;
            OPC_JUMP: cls.jump    = 1'b1;
            OPC_JZ:   cls.jz      = 1'b1;
            OPC_JNZ:  cls.jnz     = 1'b1;
            OPC_CEQ:  cls.ceq     = 1'b1;
            OPC_CLT:  cls.clt     = 1'b1;
            OPC_DJMP: cls.djmp    = 1'b1;
            OPC_FORK: cls.fork_op = 1'b1;
            default:  cls.halt    = 1'b1;
        endcase
    end

endmodule

// File: rtl/mo_exec_lane.sv
module mo_exec_lane #(
    parameter int CORE = 8000,
    localparam int FW = $clog2(CORE)
) (
    input  logic [FW-1:0] x,
    input  logic [FW-1:0] y,
    input  logic          sub,
    output logic [FW-1:0] r
);

    localparam logic [FW:0] CV = (FW+1)'(CORE);

    logic [FW:0] sum;

    always_comb begin
        sum = {1'b0, x} + {1'b0, y};
        if (sub) begin
            if (x >= y) r = x - y;
            else        r = FW'({1'b0, x} + CV - {1'b0, y});
        end else begin
            if (sum >= CV) r = FW'(sum - CV);
            else           r = sum[FW-1:0];
        end
    end

endmodule

// File: rtl/mo_exec_unit.sv
module mo_exec_unit
    import mo_exec_pkg::*;
#(
    parameter int CORE = 8000,
    localparam int FW = $clog2(CORE),
    localparam int WW = 8 + 2 * FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [FW-1:0] pc,
    input  logic [WW-1:0] instr,
    input  logic          a_imm,
    input  logic [FW-1:0] a_ptr,
    input  logic [WW-1:0] a_word,
    input  logic          b_imm,
    input  logic [FW-1:0] b_ptr,
    input  logic [WW-1:0] b_word,
    output logic          out_valid,
    output logic [2:0]    cmd,
    output logic [FW-1:0] next_pc,
    output logic [FW-1:0] spawn_pc,
    output logic          wr_en,
    output logic [FW-1:0] wr_addr,
    output logic [WW-1:0] wr_data
);

    localparam int NLANE = 4;  // A-field, B-field, PC+1, PC+2

    typedef struct packed {
        logic          vld;
        sched_cmd_e    cmd;
        logic [FW-1:0] npc;
        logic [FW-1:0] spc;
        logic          we;
        logic [FW-1:0] wa;
        logic [WW-1:0] wd;
    } res_t;

    res_t res_d, res_q;
    op_class_t cls;

    logic [WW-1:0] tgt_w;
    logic [FW-1:0] tgt_a;
    logic [FW-1:0] ins_af, src_val;
    logic [FW-1:0] lx [NLANE];
    logic [FW-1:0] ly [NLANE];
    logic [FW-1:0] lr [NLANE];
    logic          ls [NLANE];
    logic          cmp_eq, cmp_lt;

    mo_exec_decode u_dec (
        .opcode (instr[WW-1 -: 4]),
        .cls    (cls)
    );

    always_comb begin
        tgt_w   = b_imm ? instr : b_word;
        tgt_a   = b_imm ? pc : b_ptr;
        ins_af  = instr[2*FW-1:FW];
        src_val = a_imm ? ins_af : a_word[FW-1:0];

        lx[0] = tgt_w[2*FW-1:FW];
        ly[0] = a_word[2*FW-1:FW];
        ls[0] = cls.sub;
        lx[1] = tgt_w[FW-1:0];
        ly[1] = cls.djmp ? FW'(1) : src_val;
        ls[1] = cls.sub | cls.djmp;
        lx[2] = pc;
        ly[2] = FW'(1);
        ls[2] = 1'b0;
        lx[3] = pc;
        ly[3] = FW'(2);
        ls[3] = 1'b0;

        cmp_eq = a_imm ? (ins_af == tgt_w[FW-1:0]) : (a_word == tgt_w);
        cmp_lt = src_val < tgt_w[FW-1:0];
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        mo_exec_lane #(.CORE(CORE)) u_lane (
            .x   (lx[g]),
            .y   (ly[g]),
            .sub (ls[g]),
            .r   (lr[g])
        );
    end

    always_comb begin
        res_d     = '0;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.cmd = CMD_NEXT;
            res_d.npc = lr[2];
            if (cls.halt) begin
                res_d.cmd = CMD_HALT;
                res_d.npc = '0;
            end else if (cls.move) begin
                res_d.we = 1'b1;
                res_d.wa = tgt_a;
                res_d.wd = a_imm ? {tgt_w[WW-1:FW], ins_af} : a_word;
            end else if (cls.add || cls.sub) begin
                res_d.we = 1'b1;
                res_d.wa = tgt_a;
                res_d.wd = a_imm ? {tgt_w[WW-1:FW], lr[1]}
                                 : {tgt_w[WW-1:2*FW], lr[0], lr[1]};
            end else if (cls.jump) begin
                res_d.cmd = CMD_BRANCH;
                res_d.npc = a_ptr;
            end else if (cls.jz || cls.jnz) begin
                if ((tgt_w[FW-1:0] == '0) == cls.jz) begin
                    res_d.cmd = CMD_BRANCH;
                    res_d.npc = a_ptr;
                end
            end else if (cls.ceq || cls.clt) begin
                if (cls.ceq ? cmp_eq : cmp_lt) begin
                    res_d.cmd = CMD_SKIP;
                    res_d.npc = lr[3];
                end
            end else if (cls.djmp) begin
                res_d.we = 1'b1;
                res_d.wa = tgt_a;
                res_d.wd = {tgt_w[WW-1:FW], lr[1]};
                if (lr[1] != '0) begin
                    res_d.cmd = CMD_BRANCH;
                    res_d.npc = a_ptr;
                end
            end else begin
                res_d.cmd = CMD_SPAWN;
                res_d.spc = a_ptr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign cmd       = res_q.cmd;
    assign next_pc   = res_q.npc;
    assign spawn_pc  = res_q.spc;
    assign wr_en     = res_q.we;
    assign wr_addr   = res_q.wa;
    assign wr_data   = res_q.wd;

endmodule

// File: rtl/mo_exec_unit_chk.sv
module mo_exec_unit_chk #(
    parameter int CORE = 8000,
    localparam int FW = $clog2(CORE),
    localparam int WW = 8 + 2 * FW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [WW-1:0] instr,
    input logic [FW-1:0] a_ptr,
    input logic          out_valid,
    input logic [2:0]    cmd,
    input logic [FW-1:0] next_pc,
    input logic [FW-1:0] spawn_pc,
    input logic          wr_en
);

    localparam logic [FW:0] CV = (FW+1)'(CORE);

    logic [3:0] opc;
    assign opc = instr[WW-1 -: 4];

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && cmd == 3'd0));

    // R2
    halt_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opc == 4'd0 || opc > 4'd10)) |=> (cmd == 3'd5 && !wr_en));

    // R3
    move_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == 4'd1) |=> (wr_en && cmd == 3'd1));

    // R5
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == 4'd4) |=> (cmd == 3'd2 && next_pc == $past(a_ptr) && !wr_en));

    // R9
    spawn_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == 4'd10) |=> (cmd == 3'd4 && spawn_pc == $past(a_ptr) && !wr_en));

    // R10
    pc_in_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, next_pc} < CV && {1'b0, spawn_pc} < CV));

endmodule

bind mo_exec_unit mo_exec_unit_chk #(.CORE(CORE)) u_chk (.*);

// File: tb/tb_mo_exec_unit.sv
`timescale 1ns/1ps
module tb_mo_exec_unit;

    localparam int C  = 10;
    localparam int FW = 4;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [FW-1:0] pc = '0;
    logic [WW-1:0] instr = '0;
    logic          a_imm = 1'b0;
    logic [FW-1:0] a_ptr = '0;
    logic [WW-1:0] a_word = '0;
    logic          b_imm = 1'b0;
    logic [FW-1:0] b_ptr = '0;
    logic [WW-1:0] b_word = '0;
    logic          out_valid;
    logic [2:0]    cmd;
    logic [FW-1:0] next_pc, spawn_pc, wr_addr;
    logic          wr_en;
    logic [WW-1:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mo_exec_unit #(.CORE(C)) dut (
        .clk, .rst_n, .in_valid, .pc, .instr, .a_imm, .a_ptr, .a_word,
        .b_imm, .b_ptr, .b_word, .out_valid, .cmd, .next_pc, .spawn_pc,
        .wr_en, .wr_addr, .wr_data
    );

    function automatic logic [15:0] mk(int op, int am, int bm, int af, int bf);
        return {4'(op), 2'(am), 2'(bm), 4'(af), 4'(bf)};
    endfunction

    function automatic int fa(logic [15:0] w); return int'(w[7:4]); endfunction
    function automatic int fb(logic [15:0] w); return int'(w[3:0]); endfunction
    function automatic int madd(int x, int y); return (x + y) % C; endfunction
    function automatic int msub(int x, int y); return (x - y + C) % C; endfunction

    task automatic check(string req, logic [40:0] got, logic [40:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h (vld,cmd,npc,spc,we,wa,wd)", req, got, exp);
        end
    endtask

    function automatic logic [40:0] outs();
        return {out_valid, cmd, next_pc, spawn_pc, wr_en, wr_addr, wr_data};
    endfunction

    // Drive one instruction, compute the expected result from the requirements, check it
    task automatic exec(string req, int op, bit ai, int ap, logic [15:0] aw,
                        bit bi, int bp, logic [15:0] bw, int p, int iaf, int ibf);
        logic [15:0] iw, tw, ewd;
        int ta, ecmd, enpc, espc, ewa, sv;
        bit ewe;
        iw = mk(op, 1, 2, iaf, ibf);
        tw = bi ? iw : bw;
        ta = bi ? p : bp;
        ecmd = 1; enpc = (p + 1) % C; espc = 0; ewe = 0; ewa = 0; ewd = '0;
        sv = ai ? iaf : fb(aw);
        case (op)
            1: begin ewe = 1; ewa = ta; ewd = ai ? {tw[15:4], 4'(iaf)} : aw; end
            2, 3: begin
                ewe = 1; ewa = ta;
                if (ai) ewd = {tw[15:4], 4'(op == 2 ? madd(fb(tw), iaf) : msub(fb(tw), iaf))};
                else ewd = {tw[15:8],
                            4'(op == 2 ? madd(fa(tw), fa(aw)) : msub(fa(tw), fa(aw))),
                            4'(op == 2 ? madd(fb(tw), fb(aw)) : msub(fb(tw), fb(aw)))};
            end
            4: begin ecmd = 2; enpc = ap; end
            5: if (fb(tw) == 0) begin ecmd = 2; enpc = ap; end
            6: if (fb(tw) != 0) begin ecmd = 2; enpc = ap; end
            7: if (ai ? (iaf == fb(tw)) : (aw == tw)) begin ecmd = 3; enpc = (p + 2) % C; end
            8: if (sv < fb(tw)) begin ecmd = 3; enpc = (p + 2) % C; end
            9: begin
                ewe = 1; ewa = ta; ewd = {tw[15:4], 4'(msub(fb(tw), 1))};
                if (msub(fb(tw), 1) != 0) begin ecmd = 2; enpc = ap; end
            end
            10: begin ecmd = 4; espc = ap; end
            default: begin ecmd = 5; enpc = 0; end
        endcase
        in_valid = 1'b1; pc = 4'(p); instr = iw; a_imm = ai; a_ptr = 4'(ap);
        a_word = aw; b_imm = bi; b_ptr = 4'(bp); b_word = bw;
        @(negedge clk);
        check(req, outs(), {1'b1, 3'(ecmd), 4'(enpc), 4'(espc), ewe, 4'(ewa), ewd});
    endtask

    task automatic idle_check(string req);
        in_valid = 1'b0;
        @(negedge clk);
        check(req, outs(), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", outs(), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", outs(), '0);

        // R2: every opcode value, halt codes included
        for (int op = 0; op < 16; op++)
            exec("R2 opcode sweep", op, 0, 3, mk(2, 0, 1, 4, 5), 0, 7, mk(1, 1, 0, 4, 5), op % C, 2, 6);
        exec("R2 all-zero word halts", 0, 0, 0, '0, 0, 0, '0, 0, 0, 0);
        idle_check("R1 gap");

        // R3 move, both A modes
        for (int v = 0; v < C; v++) begin
            exec("R3 move imm", 1, 1, 0, mk(3, 1, 1, 7, 7), 0, (v + 4) % C, mk(6, 2, 3, 8, 1), v, v, 2);
            exec("R3 move word", 1, 0, v, mk(v % 16, 3, 0, v, 9 - v), 0, (v * 7) % C, mk(6, 2, 3, 8, 1), v, 5, 2);
        end

        // R4 add/sub, every field pair, both modes
        for (int x = 0; x < C; x++)
            for (int y = 0; y < C; y++) begin
                exec("R4 add imm", 2, 1, 0, '0, 0, y, mk(0, 0, 0, y, x), (x + y) % C, y, 0);
                exec("R4 sub imm", 3, 1, 0, '0, 0, y, mk(5, 1, 2, 3, x), (x * 3) % C, y, 0);
                exec("R4 add both", 2, 0, x, mk(9, 1, 1, y, x), 0, y, mk(4, 2, 3, x, y), y, 1, 1);
                exec("R4 sub both", 3, 0, x, mk(9, 1, 1, y, x), 0, y, mk(4, 2, 3, x, y), x, 1, 1);
            end

        // R5 jumps, R10 wrap via pc rotation
        for (int v = 0; v < C; v++) begin
            exec("R5 jump", 4, 0, (v + 5) % C, '0, 0, 1, mk(0, 0, 0, 0, v), v, 0, 0);
            exec("R5 jz", 5, 0, (v + 2) % C, '0, 0, 1, mk(0, 0, 0, 4, v), v, 0, 0);
            exec("R5 jnz R10", 6, 0, (v + 2) % C, '0, 0, 1, mk(0, 0, 0, 4, v), v, 0, 0);
        end

        // R6 compare: immediate pairs, then whole words differing in one part
        for (int x = 0; x < C; x++)
            for (int y = 0; y < C; y++)
                exec("R6 ceq imm R10", 7, 1, 0, '0, 0, 2, mk(1, 0, 0, 6, y), (x + y) % C, x, 0);
        exec("R6 ceq words equal", 7, 0, 1, mk(2, 1, 3, 4, 5), 0, 2, mk(2, 1, 3, 4, 5), 9, 0, 0);
        exec("R6 ceq opcode differs", 7, 0, 1, mk(3, 1, 3, 4, 5), 0, 2, mk(2, 1, 3, 4, 5), 9, 0, 0);
        exec("R6 ceq mode differs", 7, 0, 1, mk(2, 0, 3, 4, 5), 0, 2, mk(2, 1, 3, 4, 5), 8, 0, 0);
        exec("R6 ceq afield differs", 7, 0, 1, mk(2, 1, 3, 3, 5), 0, 2, mk(2, 1, 3, 4, 5), 8, 0, 0);
        exec("R6 ceq bfield differs", 7, 0, 1, mk(2, 1, 3, 4, 6), 0, 2, mk(2, 1, 3, 4, 5), 8, 0, 0);

        // R7 less-than, every pair, both modes
        for (int x = 0; x < C; x++)
            for (int y = 0; y < C; y++) begin
                exec("R7 clt imm", 8, 1, 0, mk(0, 0, 0, 9, 9), 0, 3, mk(0, 0, 0, 0, y), (x + 2 * y) % C, x, 0);
                exec("R7 clt word", 8, 0, 4, mk(0, 0, 0, 9, x), 0, 3, mk(0, 0, 0, 0, y), (x + y + 1) % C, 9, 0);
            end

        // R8 decrement-and-jump, R11 immediate B uses the instruction itself
        for (int v = 0; v < C; v++) begin
            exec("R8 djmp", 9, 0, (v + 3) % C, '0, 0, (v + 6) % C, mk(7, 1, 1, 2, v), v, 0, 0);
            exec("R8 R11 djmp imm B", 9, 0, (v + 3) % C, '0, 1, 5, mk(7, 1, 1, 2, 4), v, 6, v);
        end
        exec("R11 move imm to self", 1, 1, 0, '0, 1, 3, mk(4, 0, 0, 1, 1), 7, 8, 2);
        exec("R11 add imm to self", 2, 1, 0, '0, 1, 3, mk(4, 0, 0, 1, 1), 6, 7, 5);

        // R9 spawn, pc rotation covers the wrap of PC+1
        for (int v = 0; v < C; v++)
            exec("R9 spawn R10", 10, 0, (v + 4) % C, '0, 0, 2, mk(0, 0, 0, 0, 3), v, 0, 0);

        idle_check("R1 idle after run");
        idle_check("R1 idle twice");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule